// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the status byte that a flash-style memory returns when the host reads it while an internal program or erase is running, while an erase is on hold, or after an operation has failed. It carries two toggle flip-flops. The first tracks overall activity. The second tracks whether the sector being read is one of the sectors marked for erase. It also carries an error flag that stays set until the host issues a reset command. A read that needs no status is flagged as an array read, and the array data path outside this block supplies that data.

The block also decodes the read address into a sector number using an asymmetric boot-block map of eleven sectors over a 512 KB byte space. The `boot_top` pin picks one of two layouts. In the top layout the small sectors sit at the high end of the space. In the bottom layout they sit at the low end. The operation engine supplies the busy, suspend and error flags and the bitmap of sectors chosen for erase.

Top module: `op_status_rpt`

## Requirements
- R1: During a status read while `op_busy`=1 and `op_susp`=0, `stat_data[6]` reports the activity toggle and then inverts it. Successive such reads return 0, 1, 0, and so on after an operation starts.
- R2: The sector toggle, reported on `stat_data[2]`, inverts after a status read only when the decoded sector has its bit set in `erase_sel`. A status read of a sector that is not selected leaves it unchanged.
- R3: While `op_susp`=1, a read of a selected sector returns status with `stat_data[6]` holding steady across reads, while `stat_data[2]` keeps toggling. A read of a sector that is not selected returns array data (`stat_sel`=0).
- R4: A high `op_err` sets a sticky error shown on `stat_data[5]`. Every read then returns status (`stat_sel`=1) until `rst_cmd` is pulsed while `op_err` is low.
- R5: With `boot_top`=1, byte-address bits [18:16] below 7 give sector 0 to 6. 70000h-77FFFh gives sector 7. 78000h-79FFFh gives 8. 7A000h-7BFFFh gives 9. 7C000h-7FFFFh gives 10.
- R6: With `boot_top`=0, 00000h-03FFFh gives sector 0. 04000h-05FFFh gives 1. 06000h-07FFFh gives 2. 08000h-0FFFFh gives 3. Each 64 KB block from 10000h upward gives sectors 4 to 10.
- R7: `stat_data` bits 7, 4, 3, 1 and 0 are always 0. The whole byte is 00h on an array read.
- R8: A rising edge of `op_busy` clears both toggles, so the first status read of a new operation shows 0 in bits 6 and 2.
- R9: With `op_busy`=0, `op_susp`=0 and no error held, a read returns array data (`stat_sel`=0). After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_top | input | 1 | 1 selects the top boot layout, 0 the bottom layout |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | AW | Byte address of the read |
| op_busy | input | 1 | Embedded operation in progress |
| op_susp | input | 1 | Erase suspended |
| op_err | input | 1 | Operation failure from the engine |
| rst_cmd | input | 1 | Reset command, clears a held error |
| erase_sel | input | 11 | Sectors chosen for erase, bit n is sector n |
| stat_sel | output | 1 | 1 means the last read returned status, 0 means array data |
| stat_data | output | 8 | Status byte of the last read |
| rd_sect | output | 4 | Sector number decoded for the last read |

## Verification
Each output is registered once, so a read strobed in one cycle shows its `stat_sel`, `stat_data` and `rd_sect` after the next rising edge and holds them until the next read. The bench drives the strobe on a falling edge, releases it on the following falling edge, and samples there. That sample point is half a cycle after the update edge. Changes to the flag inputs, including the busy rising edge that clears the toggles, get one idle cycle before the next read. This way the clear lands on an edge with no read pending.

// File: rtl/op_status_rpt.sv
module op_status_rpt #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_top,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          op_busy,
  input  logic          op_susp,
  input  logic          op_err,
  input  logic          rst_cmd,
  input  logic [10:0]   erase_sel,
  output logic          stat_sel,
  output logic [7:0]    stat_data,
  output logic [3:0]    rd_sect
);
  localparam int NSEC = 11;

  logic [2:0] hi, mid;
  logic [3:0] sec;
  logic       hit, active, start;
  logic       busy_q, err_q, t6, t2;

  assign hi  = rd_addr[AW-1:AW-3];
  assign mid = rd_addr[AW-4:AW-6];

  always_comb begin
    if (boot_top) begin
      if (hi != 3'd7)  sec = {1'b0, hi};
      else if (!mid[2]) sec = 4'd7;
      else if (!mid[1]) sec = mid[0] ? 4'd9 : 4'd8;
      else              sec = 4'd10;
    end else begin
      if (hi != 3'd0)  sec = {1'b0, hi} + 4'd3;
      else if (mid[2])  sec = 4'd3;
      else if (!mid[1]) sec = 4'd0;
      else              sec = mid[0] ? 4'd2 : 4'd1;
    end
  end

  assign hit    = |(erase_sel & (NSEC'(1) << sec));
  assign active = err_q | (op_busy & ~op_susp) | (op_susp & hit);
  assign start  = op_busy & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      err_q     <= 1'b0;
      t6        <= 1'b0;
      t2        <= 1'b0;
      stat_sel  <= 1'b0;
      stat_data <= 8'h00;
      rd_sect   <= 4'd0;
    end else begin
      busy_q <= op_busy;
      if (op_err)       err_q <= 1'b1;
      else if (rst_cmd) err_q <= 1'b0;
      if (start) begin
        t6 <= 1'b0;
        t2 <= 1'b0;
      end else if (rd_en && active) begin
        if (!op_susp) t6 <= ~t6;
        if (hit)      t2 <= ~t2;
      end
      if (rd_en) begin
        stat_sel  <= active;
        stat_data <= active ? {1'b0, t6, err_q, 2'b00, t2, 2'b00} : 8'h00;
        rd_sect   <= sec;
      end
    end
  end

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && op_susp && !start) |=> (t6 == $past(t6))); // R3
  AST_SECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !start) |=> (t2 == $past(t2))); // R2
  AST_ERR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && err_q) |=> stat_sel); // R4
  AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !op_busy && !op_susp && !err_q) |=> !stat_sel); // R9
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!t6 && !t2)); // R8
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data & 8'b1001_1011) == 8'h00); // R7
  AST_SECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sect <= 4'd10); // R5
endmodule

// File: tb/op_status_rpt_test.sv
module op_status_rpt_test;
  logic        clk = 0, rst_n = 0, boot_top = 1, rd_en = 0;
  logic [18:0] rd_addr = '0;
  logic        op_busy = 0, op_susp = 0, op_err = 0, rst_cmd = 0;
  logic [10:0] erase_sel = '0;
  logic        stat_sel;
  logic [7:0]  stat_data;
  logic [3:0]  rd_sect;
  int checks = 0, errors = 0;
  bit done = 0;

  op_status_rpt uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic idle(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [18:0] a);
    rd_addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R9 reset sel", stat_sel, 0);
    chk("R9 reset data", stat_data, 0);
    chk("R9 reset sect", rd_sect, 0);
  endtask

  task automatic t_decode;
    logic [18:0] ta[8] = '{19'h00000, 19'h3ABCD, 19'h6FFFF, 19'h70000,
                           19'h77FFF, 19'h78000, 19'h7A000, 19'h7FFFF};
    int te[8] = '{0, 3, 6, 7, 7, 8, 9, 10};
    logic [18:0] ba[8] = '{19'h00000, 19'h03FFF, 19'h04000, 19'h06000,
                           19'h08000, 19'h0FFFF, 19'h10000, 19'h7FFFF};
    int be[8] = '{0, 0, 1, 2, 3, 3, 4, 10};
    boot_top = 1;
    foreach (ta[i]) begin rd(ta[i]); chk("R5 top sector", rd_sect, te[i]); end
    boot_top = 0;
    foreach (ba[i]) begin rd(ba[i]); chk("R6 bottom sector", rd_sect, be[i]); end
    chk("R9 idle array", stat_sel, 0);
    chk("R7 array byte", stat_data, 0);
    boot_top = 1;
  endtask

  task automatic t_program;
    op_busy = 1; erase_sel = '0; idle();
    for (int i = 0; i < 4; i++) begin
      rd(19'h12345);
      chk("R1 status sel", stat_sel, 1);
      chk("R1 toggle6", stat_data[6], i % 2);
      chk("R2 unselected toggle2", stat_data[2], 0);
      chk("R7 fixed bits", stat_data & 8'h9B, 0);
    end
    op_busy = 0; idle();
    rd(19'h12345);
    chk("R9 after busy", stat_sel, 0);
  endtask

  task automatic t_erase_susp;
    op_busy = 1; erase_sel = 11'h008; idle();
    rd(19'h30000); chk("R8 first b6", stat_data[6], 0); chk("R8 first b2", stat_data[2], 0);
    rd(19'h00000); chk("R1 b6", stat_data[6], 1); chk("R2 b2 after hit", stat_data[2], 1);
    rd(19'h30000); chk("R1 b6", stat_data[6], 0); chk("R2 b2 held", stat_data[2], 1);
    rd(19'h30000); chk("R1 b6", stat_data[6], 1); chk("R2 b2 toggled", stat_data[2], 0);
    op_susp = 1; idle();
    rd(19'h30000); chk("R3 b6 hold", stat_data[6], 0); chk("R3 b2", stat_data[2], 1);
    rd(19'h30000); chk("R3 b6 hold", stat_data[6], 0); chk("R3 b2", stat_data[2], 0);
    rd(19'h50000); chk("R3 nonsel array", stat_sel, 0);
    rd(19'h30000); chk("R3 b6 hold", stat_data[6], 0); chk("R3 b2", stat_data[2], 1);
    op_susp = 0; idle();
    rd(19'h30000); chk("R1 resume b6", stat_data[6], 0);
    rd(19'h30000); chk("R1 resume b6", stat_data[6], 1);
    op_busy = 0; idle();
    op_busy = 1; idle();
    rd(19'h30000);
    chk("R8 restart b6", stat_data[6], 0);
    chk("R8 restart b2", stat_data[2], 0);
    op_busy = 0; erase_sel = '0; idle();
  endtask

  task automatic t_error;
    op_busy = 1; idle();
    op_err = 1; idle();
    op_err = 0; op_busy = 0; idle();
    for (int i = 0; i < 3; i++) begin
      rd(19'h01000);
      chk("R4 err sel", stat_sel, 1);
      chk("R4 err bit", stat_data[5], 1);
    end
    rst_cmd = 1; idle(); rst_cmd = 0;
    rd(19'h01000);
    chk("R4 cleared sel", stat_sel, 0);
    chk("R4 cleared byte", stat_data, 0);
  endtask

  initial begin
    idle(2); rst_n = 1; idle();
    t_reset();
    t_decode();
    t_program();
    t_erase_susp();
    t_error();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule